// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block supervises a frequency-select code that software may have pushed past what the system tolerates. Once armed, it measures time in coarse ticks of 290 ms, produced by an internal prescaler from the system clock, and compares the number of elapsed ticks with a programmed 8-bit limit. Software keeps the watchdog quiet by performing register writes: each completed write transaction restarts the measurement.

If the limit is reached without a restart, the block raises an alarm flag. It then replaces the effective 5-bit frequency-select code with a stored fallback code and drives an active-low system reset pulse. The fallback stays in force until software clears the alarm. When no alarm is pending, the effective code comes either from the frequency register or from the strap pins. The strap pins are captured, inverted, while reset is held. A frequency-change event from the register side also produces the reset pulse.

Top module: `wdt_safe_freq`

## Requirements
- R1: During and just after reset, `alarm_o` is 0 and `reset_n_o` is 1.
- R2: While `rst` is high, the strap pins are captured as their bitwise inverse. After reset, the captured value holds and later pin changes have no effect on `freq_sel_o`.
- R3: With no alarm, `freq_sel_o` follows `reg_code_i` when `sel_src_i` is 1 and the captured strap code when `sel_src_i` is 0, one clock after the inputs.
- R4: With the watchdog enabled and `kick_i` sampled high at edge K, and no later kick, the alarm rises exactly at edge K + N·TICK_DIV, where N = `wd_count_i` (N ≥ 1). It is low one cycle earlier.
- R5: A kick (`kick_i` high for one cycle) restarts both the tick phase and the tick count. Kicks spaced closer than the timeout prevent the alarm, and the timeout is measured from the last kick.
- R6: While `wd_enable_i` is 0, the alarm never rises.
- R7: A count of 0 expires on the first tick, at edge K + TICK_DIV.
- R8: While the alarm is set, `freq_sel_o` equals `safe_code_i`, and changes on `reg_code_i` or `sel_src_i` have no effect.
- R9: `alarm_clr_i` clears the alarm at the next edge (a simultaneous expiry wins), and the normal source is restored in the same cycle.
- R10: An expiry drives `reset_n_o` low at the same edge as the alarm rises, for exactly RST_CYCLES (default 16) clocks.
- R11: `freq_change_i` high at edge F drives `reset_n_o` low from edge F for exactly RST_CYCLES clocks.
- R12: A trigger that arrives while the pulse is active extends the pulse, so that `reset_n_o` stays low until RST_CYCLES clocks after the last trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap capture window |
| strap_pins_i | input | 5 | Strap pin levels, inverted and captured during reset |
| wd_count_i | input | 8 | Timeout in 290 ms ticks |
| wd_enable_i | input | 1 | Watchdog enable, 1 = armed |
| safe_code_i | input | 5 | Fallback frequency code applied on alarm |
| sel_src_i | input | 1 | 1 = register code, 0 = captured strap code |
| reg_code_i | input | 5 | Frequency code from the register interface |
| freq_change_i | input | 1 | One-cycle event: frequency value changed |
| kick_i | input | 1 | One-cycle event: valid register write, restarts watchdog |
| alarm_clr_i | input | 1 | One-cycle event: software clears the alarm bit |
| freq_sel_o | output | 5 | Effective frequency-select code |
| alarm_o | output | 1 | Alarm status, 1 = watchdog expired |
| reset_n_o | output | 1 | Active-low system reset pulse |

## Verification
The hardest situation to reach from the ports is a trigger that lands while a reset pulse is already running, together with an alarm that has to stay pinned to the fallback code while the register source keeps changing. The bench shortens the tick to a few clocks through the prescaler parameter. This lets an expiry be scheduled to an exact edge from a known kick. The bench then issues a second frequency-change event six cycles into a running pulse and rewrites the register code during the alarm. The scoreboard entries for those steps check the precise edges where the pulse should and should not end.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int FSEL_W = 5;
  typedef logic [FSEL_W-1:0] fsel_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 9_570_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] phase;

  assign tick = (phase == LAST) && !hold;

  always_ff @(posedge clk) begin
    if (rst || hold)        phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/wdt_expiry_counter.sv
module wdt_expiry_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W:0]   next_count;

  assign next_count = {1'b0, elapsed} + 1'b1;
  // a limit of zero is already met by the first tick
  assign expire = tick && !restart && (next_count >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || restart) elapsed <= '0;
    else if (tick && !(&elapsed)) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/wdt_sel_mux.sv
module wdt_sel_mux
  import wdt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  fsel_t strap_pins,
  input  logic  sel_src,
  input  fsel_t reg_code,
  input  fsel_t safe_code,
  input  logic  use_safe,
  output fsel_t freq_sel
);
  fsel_t strap_q;
  fsel_t normal_code;

  assign normal_code = sel_src ? reg_code : strap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q  <= ~strap_pins;
      freq_sel <= ~strap_pins;
    end else begin
      freq_sel <= use_safe ? safe_code : normal_code;
    end
  end
endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic reset_n
);
  localparam int PULSE_W = $clog2(RST_CYCLES + 1);
  localparam logic [PULSE_W-1:0] LOAD = PULSE_W'(RST_CYCLES);

  logic [PULSE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      reset_n <= 1'b1;
    end else if (trigger) begin
      remain  <= LOAD;
      reset_n <= 1'b0;
    end else if (remain > 1) begin
      remain  <= remain - 1'b1;
      reset_n <= 1'b0;
    end else begin
      remain  <= '0;
      reset_n <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_safe_freq.sv
module wdt_safe_freq
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TICK_DIV   = 9_570_000,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       strap_pins_i,
  input  logic [CNT_W-1:0] wd_count_i,
  input  logic             wd_enable_i,
  input  logic [4:0]       safe_code_i,
  input  logic             sel_src_i,
  input  logic [4:0]       reg_code_i,
  input  logic             freq_change_i,
  input  logic             kick_i,
  input  logic             alarm_clr_i,
  output logic [4:0]       freq_sel_o,
  output logic             alarm_o,
  output logic             reset_n_o
);
  logic  hold_count;
  logic  tick;
  logic  expire;
  logic  alarm_next;
  fsel_t sel_q;

  // counting is frozen while disarmed, alarmed, or being kicked
  assign hold_count = kick_i || !wd_enable_i || alarm_o;

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .hold(hold_count), .tick(tick)
  );

  wdt_expiry_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(hold_count), .tick(tick),
    .limit(wd_count_i), .expire(expire)
  );

  // expiry takes priority over a simultaneous clear
  always_comb begin
    alarm_next = alarm_o;
    if (alarm_clr_i) alarm_next = 1'b0;
    if (expire)      alarm_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_o <= 1'b0;
    else     alarm_o <= alarm_next;
  end

  wdt_sel_mux u_mux (
    .clk(clk), .rst(rst), .strap_pins(strap_pins_i), .sel_src(sel_src_i),
    .reg_code(reg_code_i), .safe_code(safe_code_i), .use_safe(alarm_next),
    .freq_sel(sel_q)
  );
  assign freq_sel_o = sel_q;

  wdt_reset_stretch #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .trigger(expire || freq_change_i), .reset_n(reset_n_o)
  );
endmodule

// File: rtl/wdt_safe_freq_checker.sv
module wdt_safe_freq_checker (
  input logic       clk,
  input logic       rst,
  input logic       wd_enable_i,
  input logic [4:0] safe_code_i,
  input logic       sel_src_i,
  input logic [4:0] reg_code_i,
  input logic       freq_change_i,
  input logic [4:0] freq_sel_o,
  input logic       alarm_o,
  input logic       reset_n_o
);
  // R3
  a_r3_reg_source: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !alarm_o && $past(sel_src_i)) |-> freq_sel_o == $past(reg_code_i));
  // R6
  a_r6_quiet_when_disarmed: assert property (@(posedge clk) disable iff (rst)
    (!wd_enable_i && !alarm_o) |=> !alarm_o);
  // R8
  a_r8_safe_held: assert property (@(posedge clk) disable iff (rst)
    (alarm_o && $past(alarm_o)) |-> freq_sel_o == $past(safe_code_i));
  // R10
  a_r10_reset_with_alarm: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_o) |-> !reset_n_o);
  // R11
  a_r11_reset_on_change: assert property (@(posedge clk) disable iff (rst)
    freq_change_i |=> !reset_n_o);
endmodule

bind wdt_safe_freq wdt_safe_freq_checker u_chk (
  .clk(clk), .rst(rst), .wd_enable_i(wd_enable_i), .safe_code_i(safe_code_i),
  .sel_src_i(sel_src_i), .reg_code_i(reg_code_i), .freq_change_i(freq_change_i),
  .freq_sel_o(freq_sel_o), .alarm_o(alarm_o), .reset_n_o(reset_n_o)
);

// File: tb/wdt_safe_freq_bench.sv
module wdt_safe_freq_bench;
  localparam int TD = 4;
  localparam int RC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap_pins_i = 5'b10110;
  logic [7:0] wd_count_i = 8'd16;
  logic       wd_enable_i = 1'b0;
  logic [4:0] safe_code_i = 5'b00011;
  logic       sel_src_i = 1'b0;
  logic [4:0] reg_code_i = 5'b01010;
  logic       freq_change_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       alarm_clr_i = 1'b0;
  logic [4:0] freq_sel_o;
  logic       alarm_o;
  logic       reset_n_o;

  wdt_safe_freq #(.CNT_W(8), .TICK_DIV(TD), .RST_CYCLES(RC)) u_wdt_safe_freq (
    .clk(clk), .rst(rst), .strap_pins_i(strap_pins_i), .wd_count_i(wd_count_i),
    .wd_enable_i(wd_enable_i), .safe_code_i(safe_code_i), .sel_src_i(sel_src_i),
    .reg_code_i(reg_code_i), .freq_change_i(freq_change_i), .kick_i(kick_i),
    .alarm_clr_i(alarm_clr_i), .freq_sel_o(freq_sel_o), .alarm_o(alarm_o),
    .reset_n_o(reset_n_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {int cyc; int kind; int val; string req;} exp_t;
  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // kind: 0 alarm_o, 1 reset_n_o, 2 freq_sel_o
  task automatic expect_at(input int at, input int kind, input int val, input string req);
    exp_t e;
    e.cyc = at; e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        int got;
        got = (q[i].kind == 0) ? int'(alarm_o) : (q[i].kind == 1) ? int'(reset_n_o) : int'(freq_sel_o);
        checks++;
        if (got !== q[i].val) begin
          errors++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                   q[i].req, q[i].kind, cyc, got, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (q.size() != 0) begin
        errors += q.size();
        $display("FAIL pending scoreboard items actual=%0d expected=0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick_i = 1'b1;
    @(negedge clk); kick_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n, k, e, f1, f2;
    idle(3);
    rst = 1'b0;
    strap_pins_i = 5'b00000;
    n = cyc;
    expect_at(n + 1, 0, 0, "R1");
    expect_at(n + 1, 1, 1, "R1");
    expect_at(n + 1, 2, 5'b01001, "R2");
    expect_at(n + 4, 2, 5'b01001, "R2");
    idle(6);

    // R3 register source then back to strap
    sel_src_i = 1'b1; n = cyc;
    expect_at(n + 1, 2, 5'b01010, "R3");
    @(negedge clk); sel_src_i = 1'b0; n = cyc;
    expect_at(n + 1, 2, 5'b01001, "R3");
    idle(3);

    // R4 / R8 / R10 timeout with count 3
    @(negedge clk);
    wd_count_i = 8'd3; wd_enable_i = 1'b1; kick_i = 1'b1;
    k = cyc + 1; e = k + 3 * TD;
    @(negedge clk); kick_i = 1'b0;
    expect_at(e - 1, 0, 0, "R4");
    expect_at(e, 0, 1, "R4");
    expect_at(e, 2, 5'b00011, "R8");
    expect_at(e - 1, 1, 1, "R10");
    expect_at(e, 1, 0, "R10");
    expect_at(e + RC - 1, 1, 0, "R10");
    expect_at(e + RC, 1, 1, "R10");
    while (cyc < e + RC + 2) @(negedge clk);
    sel_src_i = 1'b1; reg_code_i = 5'b11100; n = cyc;
    expect_at(n + 2, 2, 5'b00011, "R8");
    expect_at(n + 2, 0, 1, "R8");
    idle(4);

    // R9 clear with kick, then R5 kicks keep it quiet
    @(negedge clk); alarm_clr_i = 1'b1; kick_i = 1'b1; n = cyc;
    expect_at(n + 1, 0, 0, "R9");
    expect_at(n + 1, 2, 5'b11100, "R9");
    @(negedge clk); alarm_clr_i = 1'b0; kick_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      idle(7);
      pulse_kick();
    end
    k = cyc; e = k + 3 * TD;
    expect_at(k + 9, 0, 0, "R5");
    expect_at(e - 1, 0, 0, "R5");
    expect_at(e, 0, 1, "R5");
    while (cyc < e + RC + 2) @(negedge clk);

    // R6 disarmed
    alarm_clr_i = 1'b1; wd_enable_i = 1'b0;
    @(negedge clk); alarm_clr_i = 1'b0; n = cyc;
    expect_at(n + 40, 0, 0, "R6");
    expect_at(n + 40, 1, 1, "R6");
    idle(42);

    // R7 zero count
    @(negedge clk); wd_count_i = 8'd0; wd_enable_i = 1'b1; kick_i = 1'b1;
    k = cyc + 1;
    @(negedge clk); kick_i = 1'b0;
    expect_at(k + TD - 1, 0, 0, "R7");
    expect_at(k + TD, 0, 1, "R7");
    while (cyc < k + TD + RC + 2) @(negedge clk);
    alarm_clr_i = 1'b1; wd_enable_i = 1'b0;
    @(negedge clk); alarm_clr_i = 1'b0;
    idle(3);

    // R11 frequency change pulse
    @(negedge clk); freq_change_i = 1'b1; f1 = cyc + 1;
    @(negedge clk); freq_change_i = 1'b0;
    expect_at(f1, 1, 0, "R11");
    expect_at(f1 + RC - 1, 1, 0, "R11");
    expect_at(f1 + RC, 1, 1, "R11");
    while (cyc < f1 + RC + 3) @(negedge clk);

    // R12 retrigger extends
    freq_change_i = 1'b1; f1 = cyc + 1;
    @(negedge clk); freq_change_i = 1'b0;
    idle(4);
    @(negedge clk); freq_change_i = 1'b1; f2 = cyc + 1;
    @(negedge clk); freq_change_i = 1'b0;
    expect_at(f1 + RC, 1, 0, "R12");
    expect_at(f2 + RC - 1, 1, 0, "R12");
    expect_at(f2 + RC, 1, 1, "R12");
    while (cyc < f2 + RC + 3) @(negedge clk);

    finish_run();
  end
endmodule